// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line. It is clocked by the system clock and advances once on each cycle in which `sampleTick` is high. That strobe comes from an external rate divider and runs at sixteen times the bit rate. The receiver watches for a high-to-low transition on the synchronised line. It restarts its bit timer on that edge and reads the line once per bit at the midpoint of the bit. A frame is eight data bits, least significant bit first. An optional parity bit, even or odd, may follow the data. One stop bit ends the frame.

A completed frame is placed in a holding register and raises a data-available flag. Framing, parity and overrun problems each raise their own sticky flag. The synchronised line level is exported directly. Software can therefore tell a line held low (a break) apart from a single bad stop bit. The receiver does not stop while the line is held low. Each all-zero frame completes, so the framing flag comes back after software clears it.

Top module: `uart_rx_oversampled`

## Requirements
- R1: Each bit is read once, on the 8th `sampleTick` after the tick that detected the start edge, and then every 16 ticks after that. No other tick reads the line.
- R2: A start is recognised when the synchronised line is low on a tick and was high on the previous idle tick. If the line is high again at the start-bit midpoint, the receiver returns to idle and no frame is produced.
- R3: The eight data bits are assembled LSB first into `rxData`, and `dataFull` rises when the stop bit is read. After reset `dataFull` and all error flags are 0 and `lineLevel` is 1.
- R4: With `parityOn`=1, a parity bit follows the data. `parityOdd`=0 requires an even number of ones across data and parity, and `parityOdd`=1 requires an odd number. A mismatch sets `errParity`.
- R5: A stop bit read as 0 sets `errFraming`. The received byte is still delivered to `rxData` with `dataFull` set.
- R6: If a frame completes while `dataFull` is 1, `errOverrun` is set, `rxData` keeps the older byte, and the framing and parity flags are not updated by that frame.
- R7: Error flags are sticky. A one-cycle `errClear` clears all three flags and leaves `dataFull` alone, and a `dataRead` pulse clears `dataFull`. When a set and a clear fall in the same cycle, the flag ends up set.
- R8: `lineLevel` follows `rxLine` through two register stages, so a change driven on the line appears after two rising clock edges.
- R9: A line held low produces repeated all-zero frames with framing errors. After `errClear`, `errFraming` sets again while the low level lasts, and `lineLevel` reads 0 during the break.
- R10: While `rxEnable` is 0, the receiver stays idle and ignores line activity. `dataFull` and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxEnable | input | 1 | Receiver enable; low forces idle |
| parityOn | input | 1 | 1 = frame carries a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rxLine | input | 1 | Serial input line, idle high |
| dataRead | input | 1 | Pulse that clears `dataFull` |
| errClear | input | 1 | Pulse that clears all error flags |
| rxData | output | 8 | Last accepted byte |
| dataFull | output | 1 | A byte is waiting in `rxData` |
| errFraming | output | 1 | Sticky framing error |
| errParity | output | 1 | Sticky parity error |
| errOverrun | output | 1 | Sticky overrun error |
| lineLevel | output | 1 | Synchronised raw line level |

## Verification
Frame results appear one clock after the tick that reads the stop bit. That tick falls about half a bit before the stop bit ends. The driver holds the full stop bit and only then releases the frame to the monitor, so every comparison lands at least seven ticks after the flags have settled and before the next start edge. The line level is checked at the falling edge after one rising edge, where it must still show the old value, and again after the second rising edge, where it must show the new value. For break, glitch and enable cases the bench waits several whole frame times before it samples, so the result does not depend on tick phase.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // One-cycle strobes from the control to the datapath
  typedef struct packed {
    logic frameBegin;   // start bit confirmed at its midpoint
    logic shiftBit;     // capture one data bit
    logic parityBit;    // capture the parity bit
    logic frameEnd;     // stop bit being read now; commit the frame
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxEnable,
  input  logic      parityOn,
  input  logic      lineSync,
  output rxStrobe_t strb
);

  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int BIT_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID_IDX  = OVERSAMPLE / 2 - 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(MID_IDX);
  localparam logic [CNT_W-1:0] WRAP_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCount;
  logic [BIT_W-1:0] bitCount;
  logic             lastSample;
  logic             midPoint;
  logic             readNow;

  assign midPoint = (tickCount == MID_CNT);
  assign readNow  = rxEnable && sampleTick && midPoint;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCount  <= '0;
      bitCount   <= '0;
      lastSample <= 1'b0;
    end else if (!rxEnable) begin
      state      <= ST_IDLE;
      tickCount  <= '0;
      lastSample <= 1'b0;
    end else if (sampleTick) begin
      if (state == ST_IDLE) begin
        lastSample <= lineSync;
        if (lastSample && !lineSync) begin
          state     <= ST_START;
          tickCount <= '0;
        end
      end else begin
        tickCount <= (tickCount == WRAP_CNT) ? '0 : tickCount + 1'b1;
        if (midPoint) begin
          unique case (state)
            ST_START: begin
              if (lineSync) begin
                state      <= ST_IDLE;
                lastSample <= 1'b1;
              end else begin
                state    <= ST_DATA;
                bitCount <= '0;
              end
            end
            ST_DATA: begin
              bitCount <= bitCount + 1'b1;
              if (bitCount == LAST_BIT)
                state <= parityOn ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: state <= ST_STOP;
            ST_STOP: begin
              state      <= ST_IDLE;
              lastSample <= 1'b1;   // stop slot counts as mark: a held-low line re-arms
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.frameBegin = readNow && (state == ST_START) && !lineSync;
    strb.shiftBit   = readNow && (state == ST_DATA);
    strb.parityBit  = readNow && (state == ST_PARITY);
    strb.frameEnd   = readNow && (state == ST_STOP);
  end

  // R1: a line read happens only on a sample tick
  p_read_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftBit || strb.parityBit || strb.frameEnd) |-> sampleTick);

  // R1: at most one strobe per cycle
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.frameBegin, strb.shiftBit, strb.parityBit, strb.frameEnd}));

  // R2: a high level at the start-bit midpoint aborts to idle
  p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rstN)
    (readNow && state == ST_START && lineSync) |=> (state == ST_IDLE));

  // R10: disabled receiver sits in idle
  p_enable_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strb,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  logic                 dataRead,
  input  logic                 errClear,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataFull,
  output logic                 errFraming,
  output logic                 errParity,
  output logic                 errOverrun
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_BITS-1:0]   shiftReg;
  logic                   parAcc;
  logic                   accept;
  logic                   overrun;
  logic                   stopBad;
  logic                   parBad;

  // Line synchroniser, reset to mark
  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncChain[SYNC_STAGES-1];

  // Bit assembly and running parity
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strb.frameBegin) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strb.shiftBit) begin
      shiftReg <= {lineSync, shiftReg[DATA_BITS-1:1]};
      parAcc   <= parAcc ^ lineSync;
    end else if (strb.parityBit) begin
      parAcc   <= parAcc ^ lineSync;
    end
  end

  assign overrun = strb.frameEnd && dataFull;
  assign accept  = strb.frameEnd && !dataFull;
  assign stopBad = !lineSync;
  assign parBad  = parityOn && (parAcc != parityOdd);

  // Holding register and flags; a set wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      dataFull   <= 1'b0;
      errFraming <= 1'b0;
      errParity  <= 1'b0;
      errOverrun <= 1'b0;
    end else begin
      if (accept) rxData <= shiftReg;

      if (accept)        dataFull <= 1'b1;
      else if (dataRead) dataFull <= 1'b0;

      if (accept && stopBad) errFraming <= 1'b1;
      else if (errClear)     errFraming <= 1'b0;

      if (accept && parBad) errParity <= 1'b1;
      else if (errClear)    errParity <= 1'b0;

      if (overrun)       errOverrun <= 1'b1;
      else if (errClear) errOverrun <= 1'b0;
    end
  end

  // R3: data-available rises only after a frame end
  p_full_on_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataFull) |-> $past(strb.frameEnd));

  // R6: overrun keeps the older byte
  p_overrun_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameEnd && dataFull) |=> (errOverrun && $stable(rxData)));

  // R7: set beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameEnd && !dataFull && !lineSync && errClear) |=> errFraming);

  // R7: flags only fall on a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFraming || errParity || errOverrun) |-> $past(errClear));

endmodule

// File: rtl/uart_rx_oversampled.sv
module uart_rx_oversampled
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxEnable,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  logic                 rxLine,
  input  logic                 dataRead,
  input  logic                 errClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataFull,
  output logic                 errFraming,
  output logic                 errParity,
  output logic                 errOverrun,
  output logic                 lineLevel
);

  rxStrobe_t strb;
  logic      lineSync;

  uart_rx_control #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxEnable  (rxEnable),
    .parityOn  (parityOn),
    .lineSync  (lineSync),
    .strb      (strb)
  );

  uart_rx_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strb      (strb),
    .parityOn  (parityOn),
    .parityOdd (parityOdd),
    .dataRead  (dataRead),
    .errClear  (errClear),
    .lineSync  (lineSync),
    .rxData    (rxData),
    .dataFull  (dataFull),
    .errFraming(errFraming),
    .errParity (errParity),
    .errOverrun(errOverrun)
  );

  assign lineLevel = lineSync;

  // R10: nothing new arrives while disabled
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !$past(rxEnable)) |-> !$rose(dataFull));

endmodule

// File: tb/uart_rx_oversampled_test.sv
module uart_rx_oversampled_test;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxEnable = 1'b1;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rxLine = 1'b1;
  logic       dataRead = 1'b0;
  logic       errClear = 1'b0;
  logic [7:0] rxData;
  logic       dataFull, errFraming, errParity, errOverrun, lineLevel;

  uart_rx_oversampled uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxEnable(rxEnable),
    .parityOn(parityOn), .parityOdd(parityOdd), .rxLine(rxLine),
    .dataRead(dataRead), .errClear(errClear), .rxData(rxData),
    .dataFull(dataFull), .errFraming(errFraming), .errParity(errParity),
    .errOverrun(errOverrun), .lineLevel(lineLevel)
  );

  always #10 clk = ~clk;   // 50 MHz

  int tickCnt = 0;
  always @(posedge clk) begin
    tickCnt    <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    sampleTick <= (tickCnt == 0);
  end

  int  nCompared = 0;
  int  nMismatch = 0;
  bit  summaryDone = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  // Scoreboard
  typedef struct {
    string      req;
    logic [7:0] data;
    bit         full, fer, per, ovr, ack;
  } expItem_t;

  expItem_t   expQ[$];
  int         sentCount = 0;
  int         doneCount = 0;
  logic [7:0] mData = 8'h00;
  bit         mFull = 0, mFer = 0, mPer = 0, mOvr = 0;

  task automatic driveBit(input logic b);
    rxLine = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic rawFrame(input logic [7:0] d, input logic stopVal);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(stopVal);
    driveBit(1'b1);
    driveBit(1'b1);
  endtask

  task automatic sendFrame(input string req, input logic [7:0] d,
                           input bit badPar, input bit badStop, input bit ack);
    expItem_t it;
    logic     pbit;
    if (mFull) mOvr = 1;
    else begin
      mData = d; mFull = 1;
      if (badStop) mFer = 1;
      if (parityOn && badPar) mPer = 1;
    end
    it.req = req; it.data = mData; it.full = mFull;
    it.fer = mFer; it.per = mPer; it.ovr = mOvr; it.ack = ack;
    expQ.push_back(it);
    if (ack) begin mFull = 0; mFer = 0; mPer = 0; mOvr = 0; end
    pbit = (^d) ^ parityOdd ^ badPar;
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    if (parityOn) driveBit(pbit);
    driveBit(!badStop);
    sentCount++;
    driveBit(1'b1);
    driveBit(1'b1);
  endtask

  // Monitor
  initial begin
    forever begin
      expItem_t it;
      wait (sentCount > doneCount);
      @(negedge clk);
      it = expQ.pop_front();
      check(it.req, "rxData",     rxData,     it.data);
      check(it.req, "dataFull",   dataFull,   it.full);
      check(it.req, "errFraming", errFraming, it.fer);
      check(it.req, "errParity",  errParity,  it.per);
      check(it.req, "errOverrun", errOverrun, it.ovr);
      if (it.ack) begin
        dataRead = 1; errClear = 1;
        @(negedge clk);
        dataRead = 0; errClear = 0;
      end
      doneCount++;
    end
  end

  task automatic drain();
    wait (doneCount == sentCount);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseReadClear();
    dataRead = 1; errClear = 1;
    @(negedge clk);
    dataRead = 0; errClear = 0;
    @(negedge clk);
  endtask

  // Set-wins watcher: errFraming seen high while clear is held
  bit sawFer = 0;
  always @(negedge clk) if (errClear && errFraming) sawFer = 1;

  initial begin
    repeat (150000) @(posedge clk);
    nCompared++; nMismatch++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R3: reset state
    check("R3", "reset dataFull",   dataFull,   0);
    check("R3", "reset errFraming", errFraming, 0);
    check("R3", "reset errParity",  errParity,  0);
    check("R3", "reset errOverrun", errOverrun, 0);
    check("R3", "reset lineLevel",  lineLevel,  1);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R8: two-stage line view (receiver disabled so no frame starts)
    rxEnable = 0;
    rxLine = 0;
    @(negedge clk);
    check("R8", "lineLevel after 1 edge", lineLevel, 1);
    @(negedge clk);
    check("R8", "lineLevel after 2 edges", lineLevel, 0);
    rxLine = 1;
    repeat (2) @(negedge clk);
    check("R8", "lineLevel back high", lineLevel, 1);
    rxEnable = 1;
    repeat (BIT_CLKS) @(negedge clk);

    // R1 R3: plain frames, no parity
    sendFrame("R1", 8'hA5, 0, 0, 1);
    sendFrame("R3", 8'h3C, 0, 0, 1);
    sendFrame("R3", 8'h00, 0, 0, 1);
    sendFrame("R1", 8'hFF, 0, 0, 1);
    drain();

    // R4: even then odd parity
    parityOn = 1; parityOdd = 0;
    sendFrame("R4", 8'h5A, 0, 0, 1);
    sendFrame("R4", 8'h5B, 1, 0, 1);
    parityOdd = 1;
    drain();
    sendFrame("R4", 8'h81, 0, 0, 1);
    sendFrame("R4", 8'h80, 1, 0, 1);
    drain();
    parityOn = 0; parityOdd = 0;

    // R5: bad stop bit, byte still delivered
    sendFrame("R5", 8'h77, 0, 1, 1);
    // R6: overrun keeps first byte
    sendFrame("R6", 8'h11, 0, 0, 0);
    sendFrame("R6", 8'h22, 0, 0, 1);
    drain();

    // R7: sticky flags, independent clears
    sendFrame("R7", 8'h33, 0, 1, 0);
    drain();
    repeat (200) @(negedge clk);
    check("R7", "errFraming held", errFraming, 1);
    errClear = 1; @(negedge clk); errClear = 0; @(negedge clk);
    check("R7", "errFraming cleared", errFraming, 0);
    check("R7", "dataFull untouched by errClear", dataFull, 1);
    dataRead = 1; @(negedge clk); dataRead = 0; @(negedge clk);
    check("R7", "dataFull cleared by dataRead", dataFull, 0);
    mFull = 0; mFer = 0;

    // R7: set wins over a held clear
    sawFer = 0;
    errClear = 1;
    rawFrame(8'h6E, 1'b0);
    errClear = 0;
    check("R7", "set wins over clear", sawFer, 1);
    pulseReadClear();

    // R2: short low pulse is a glitch
    rxLine = 0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxLine = 1;
    repeat (40 * TICK_DIV) @(negedge clk);
    check("R2", "glitch dataFull", dataFull, 0);
    check("R2", "glitch errFraming", errFraming, 0);
    sendFrame("R2", 8'hC3, 0, 0, 1);
    drain();

    // R10: disabled receiver ignores a frame
    rxEnable = 0;
    rawFrame(8'h96, 1'b1);
    check("R10", "disabled dataFull", dataFull, 0);
    check("R10", "disabled errFraming", errFraming, 0);
    rxEnable = 1;
    repeat (2 * BIT_CLKS) @(negedge clk);

    // R9: break
    rxLine = 0;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R9", "break errFraming", errFraming, 1);
    check("R9", "break dataFull", dataFull, 1);
    check("R9", "break rxData", rxData, 8'h00);
    check("R9", "break lineLevel", lineLevel, 0);
    pulseReadClear();
    check("R9", "errFraming after clear", errFraming, 0);
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R9", "errFraming sets again", errFraming, 1);
    rxLine = 1;
    repeat (24 * BIT_CLKS) @(negedge clk);
    pulseReadClear();
    check("R9", "lineLevel after break", lineLevel, 1);
    check("R9", "flags clean after break", {errFraming, errParity, errOverrun}, 0);
    mFull = 0; mFer = 0; mPer = 0; mOvr = 0;
    sendFrame("R9", 8'hE7, 0, 0, 1);
    drain();

    finishRun();
  end

endmodule